// File: doc/BRIEF.md
# Sequenced Multi-Word Unsigned Multiplier

This block forms the full unsigned product of two operands, each made of two machine words. It does so without a wide multiplier. The datapath holds one word-by-word multiplier, one word-wide adder and a single carry flag. A fixed chain of nine micro-steps drives this datapath, one step per clock. Each step takes the low or the high half of one word product. It adds that half to a word of the partial result, and it may consume the carry flag, update it, or both. After the last step, the four result words hold the double-width product.

The caller presents both operands with a one-cycle start pulse. The block latches the operands, runs the chain, and raises a one-cycle done pulse. The four result words then stay readable until the next accepted start. A new start has no effect while a product is in flight. Only unsigned operands are handled, and requests are not overlapped.

Top module: `mwm_mult`

## Requirements
- R1: After synchronous reset, busy_o and done_o are 0 and every bit of prod_o is 0.
- R2: When done_o is high, prod_o equals the unsigned product a × b of the operands latched at the accepting start. Result word k sits in bits [(k+1)·WORD_W−1 : k·WORD_W], and word 0 is least significant.
- R3: A start is accepted when start_i is high at a rising edge with busy_o low. done_o is first high in the cycle that follows the ninth rising edge after the accepting edge.
- R4: done_o is high for exactly one cycle per accepted start.
- R5: busy_o is high from the cycle after the accepting edge until the cycle before done_o rises. busy_o falls in the same cycle that done_o rises.
- R6: A start_i pulse while busy_o is high is ignored. The running product still finishes with the original operands, at the original time, and no extra operation follows.
- R7: While busy_o is low and no start is accepted, prod_o holds its value, whatever a_i and b_i do.
- R8: Operands of all ones in both words give the product whose high two words are all ones except bit 0 of word 2, and whose low two words are 1. This exercises every carry in the chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, sampled with the operands |
| a_i | input | 2*WORD_W | Multiplicand, two words |
| b_i | input | 2*WORD_W | Multiplier, two words |
| busy_o | output | 1 | High while the micro-step chain runs |
| done_o | output | 1 | One-cycle pulse when prod_o is final |
| prod_o | output | 4*WORD_W | Product, four words, word 0 least significant |

## Verification
Some steps must propagate a carry into the top word while other steps must leave the flag untouched. Getting one of these wrong only shows up for operands whose partial-product sums overflow a word in particular combinations.

Random wide operands rarely hit every such combination. The bench therefore runs a second instance with three-bit words and sweeps every operand pair exhaustively, so every carry pattern of the chain occurs. It also checks all-ones and single-word boundary values at full width. A start pulse placed mid-chain checks that the latched operands and the timing survive the ignored request.

// File: rtl/mwm_pkg.sv
`timescale 1ns/1ps
package mwm_pkg;

    localparam int NUM_STEPS = 9;
    localparam int RES_WORDS = 4;

    // Order of the chain is behaviour: each step consumes the carry and
    // partial words left by the ones before it.
    typedef enum logic [3:0] {
        ST_LL_LO   = 4'd0,
        ST_LL_HI   = 4'd1,
        ST_HL_LO   = 4'd2,
        ST_HL_HI   = 4'd3,
        ST_LH_LO   = 4'd4,
        ST_LH_HI   = 4'd5,
        ST_TOP_CRY = 4'd6,
        ST_HH_LO   = 4'd7,
        ST_HH_HI   = 4'd8
    } step_e;

    localparam step_e LAST_STEP = ST_HH_HI;

    typedef enum logic [1:0] {
        SRC_ZERO = 2'd0,
        SRC_R1   = 2'd1,
        SRC_R2   = 2'd2,
        SRC_R3   = 2'd3
    } addend_e;

    typedef struct packed {
        logic    a_hi;     // pick upper word of operand A
        logic    b_hi;     // pick upper word of operand B
        logic    take_hi;  // use upper half of the word product
        logic    no_prod;  // product term forced to zero
        addend_e addend;   // which partial word to add
        logic    cin;      // add the carry flag
        logic    cwr;      // update the carry flag
        logic [1:0] dest;  // result word written
    } uop_t;

    function automatic uop_t decode_step(step_e s);
        uop_t u;
        u = '{a_hi: 1'b0, b_hi: 1'b0, take_hi: 1'b0, no_prod: 1'b0,
              addend: SRC_ZERO, cin: 1'b0, cwr: 1'b0, dest: 2'd0};
        case (s)
            ST_LL_LO:   begin u.dest = 2'd0; end
            ST_LL_HI:   begin u.take_hi = 1'b1; u.dest = 2'd1; end
            ST_HL_LO:   begin u.a_hi = 1'b1; u.addend = SRC_R1; u.cwr = 1'b1; u.dest = 2'd1; end
            ST_HL_HI:   begin u.a_hi = 1'b1; u.take_hi = 1'b1; u.cin = 1'b1; u.dest = 2'd2; end
            ST_LH_LO:   begin u.b_hi = 1'b1; u.addend = SRC_R1; u.cwr = 1'b1; u.dest = 2'd1; end
            ST_LH_HI:   begin u.b_hi = 1'b1; u.take_hi = 1'b1; u.addend = SRC_R2;
                              u.cin = 1'b1; u.cwr = 1'b1; u.dest = 2'd2; end
            ST_TOP_CRY: begin u.no_prod = 1'b1; u.cin = 1'b1; u.dest = 2'd3; end
            ST_HH_LO:   begin u.a_hi = 1'b1; u.b_hi = 1'b1; u.addend = SRC_R2;
                              u.cwr = 1'b1; u.dest = 2'd2; end
            ST_HH_HI:   begin u.a_hi = 1'b1; u.b_hi = 1'b1; u.take_hi = 1'b1;
                              u.addend = SRC_R3; u.cin = 1'b1; u.dest = 2'd3; end
            default:    begin u.dest = 2'd0; end
        endcase
        return u;
    endfunction

endpackage

// File: rtl/mwm_seq.sv
`timescale 1ns/1ps
module mwm_seq
    import mwm_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start_i,
    output logic  accept_o,
    output logic  busy_o,
    output logic  done_o,
    output step_e step_o
);

    logic  busy_q;
    logic  done_q;
    step_e step_q;

    assign accept_o = start_i && !busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            step_q <= ST_LL_LO;
        end else begin
            done_q <= 1'b0;
            if (accept_o) begin
                busy_q <= 1'b1;
                step_q <= ST_LL_LO;
            end else if (busy_q) begin
                if (step_q == LAST_STEP) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end else begin
                    step_q <= step_e'(step_q + 4'd1);
                end
            end
        end
    end

    assign busy_o = busy_q;
    assign done_o = done_q;
    assign step_o = step_q;

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q); // R4
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        done_q |-> ($past(busy_q) && $past(step_q) == LAST_STEP)); // R3
    AST_BUSY_HELD: assert property (@(posedge clk) disable iff (rst)
        (busy_q && step_q != LAST_STEP) |=> (busy_q && !done_q)); // R5
    AST_BUSY_FALLS_AT_DONE: assert property (@(posedge clk) disable iff (rst)
        done_q |-> !busy_q); // R5

endmodule

// File: rtl/mwm_word_alu.sv
`timescale 1ns/1ps
module mwm_word_alu #(
    parameter int WORD_W = 32
) (
    input  logic [WORD_W-1:0] x_i,
    input  logic [WORD_W-1:0] y_i,
    input  logic              take_hi_i,
    input  logic              no_prod_i,
    input  logic [WORD_W-1:0] addend_i,
    input  logic              cin_i,
    output logic [WORD_W-1:0] sum_o,
    output logic              cout_o
);

    localparam int PROD_W = 2 * WORD_W;

    logic [PROD_W-1:0] full;
    logic [WORD_W-1:0] part;
    logic [WORD_W:0]   total;

    always_comb begin
        full  = {{WORD_W{1'b0}}, x_i} * {{WORD_W{1'b0}}, y_i};
        if (no_prod_i)
            part = '0;
        else if (take_hi_i)
            part = full[PROD_W-1:WORD_W];
        else
            part = full[WORD_W-1:0];
        total = {1'b0, part} + {1'b0, addend_i} + {{WORD_W{1'b0}}, cin_i};
    end

    assign sum_o  = total[WORD_W-1:0];
    assign cout_o = total[WORD_W];

endmodule

// File: rtl/mwm_regs.sv
`timescale 1ns/1ps
module mwm_regs
    import mwm_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en_i,
    input  logic [1:0]                  dest_i,
    input  logic [WORD_W-1:0]           wdata_i,
    input  logic                        cwr_i,
    input  logic                        carry_i,
    output logic [RES_WORDS*WORD_W-1:0] words_o,
    output logic                        cf_o
);

    logic cf_q;

    for (genvar gi = 0; gi < RES_WORDS; gi++) begin : g_word
        logic [WORD_W-1:0] word_q;
        always_ff @(posedge clk) begin
            if (rst)
                word_q <= '0;
            else if (wr_en_i && dest_i == 2'(gi))
                word_q <= wdata_i;
        end
        assign words_o[gi*WORD_W +: WORD_W] = word_q;
    end

    always_ff @(posedge clk) begin
        if (rst)
            cf_q <= 1'b0;
        else if (wr_en_i && cwr_i)
            cf_q <= carry_i;
    end

    assign cf_o = cf_q;

    AST_CARRY_KEPT: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && !cwr_i) |=> $stable(cf_q)); // R2
    AST_IDLE_WORDS_KEPT: assert property (@(posedge clk) disable iff (rst)
        !wr_en_i |=> $stable(words_o)); // R7

endmodule

// File: rtl/mwm_mult.sv
`timescale 1ns/1ps
module mwm_mult
    import mwm_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start_i,
    input  logic [2*WORD_W-1:0]     a_i,
    input  logic [2*WORD_W-1:0]     b_i,
    output logic                    busy_o,
    output logic                    done_o,
    output logic [4*WORD_W-1:0]     prod_o
);

    localparam int OP_W  = 2 * WORD_W;
    localparam int RES_W = RES_WORDS * WORD_W;

    logic              accept;
    logic              busy;
    step_e             step;
    uop_t              uop;
    logic [OP_W-1:0]   a_q;
    logic [OP_W-1:0]   b_q;
    logic [WORD_W-1:0] x_w;
    logic [WORD_W-1:0] y_w;
    logic [WORD_W-1:0] addend;
    logic [WORD_W-1:0] sum;
    logic              cout;
    logic              cf;
    logic [RES_W-1:0]  words;

    mwm_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .accept_o (accept),
        .busy_o   (busy),
        .done_o   (done_o),
        .step_o   (step)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q <= '0;
            b_q <= '0;
        end else if (accept) begin
            a_q <= a_i;
            b_q <= b_i;
        end
    end

    always_comb begin
        uop = decode_step(step);
        x_w = uop.a_hi ? a_q[OP_W-1:WORD_W] : a_q[WORD_W-1:0];
        y_w = uop.b_hi ? b_q[OP_W-1:WORD_W] : b_q[WORD_W-1:0];
        case (uop.addend)
            SRC_R1:  addend = words[1*WORD_W +: WORD_W];
            SRC_R2:  addend = words[2*WORD_W +: WORD_W];
            SRC_R3:  addend = words[3*WORD_W +: WORD_W];
            default: addend = '0;
        endcase
    end

    mwm_word_alu #(.WORD_W(WORD_W)) u_alu (
        .x_i       (x_w),
        .y_i       (y_w),
        .take_hi_i (uop.take_hi),
        .no_prod_i (uop.no_prod),
        .addend_i  (addend),
        .cin_i     (uop.cin & cf),
        .sum_o     (sum),
        .cout_o    (cout)
    );

    mwm_regs #(.WORD_W(WORD_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en_i (busy),
        .dest_i  (uop.dest),
        .wdata_i (sum),
        .cwr_i   (uop.cwr),
        .carry_i (cout),
        .words_o (words),
        .cf_o    (cf)
    );

    assign busy_o = busy;
    assign prod_o = words;

    AST_OPERANDS_HELD: assert property (@(posedge clk) disable iff (rst)
        (busy && start_i) |=> ($stable(a_q) && $stable(b_q))); // R6
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start_i) |=> $stable(prod_o)); // R7

endmodule

// File: tb/mwm_mult_tb.sv
`timescale 1ns/1ps
module mwm_mult_tb;

    localparam int BW = 32;
    localparam int SW = 3;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic           rst;
    logic           start, s_start;
    logic [63:0]    a_in, b_in;
    logic [5:0]     s_a, s_b;
    logic           busy, done, s_busy, s_done;
    logic [127:0]   prod;
    logic [11:0]    s_prod;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    mwm_mult #(.WORD_W(BW)) u_dut (
        .clk(clk), .rst(rst), .start_i(start), .a_i(a_in), .b_i(b_in),
        .busy_o(busy), .done_o(done), .prod_o(prod)
    );

    mwm_mult #(.WORD_W(SW)) u_small (
        .clk(clk), .rst(rst), .start_i(s_start), .a_i(s_a), .b_i(s_b),
        .busy_o(s_busy), .done_o(s_done), .prod_o(s_prod)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic big_run(input logic [63:0] a, input logic [63:0] b,
                           output logic [127:0] p, output int lat, output bit busy_ok);
        @(negedge clk);
        start = 1'b1; a_in = a; b_in = b;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        lat = 0; busy_ok = 1'b1;
        while (!done && lat < 40) begin
            if (!busy) busy_ok = 1'b0;
            @(posedge clk);
            @(negedge clk);
            lat++;
        end
        p = prod;
    endtask

    task automatic small_run(input logic [5:0] a, input logic [5:0] b,
                             output logic [11:0] p);
        @(negedge clk);
        s_start = 1'b1; s_a = a; s_b = b;
        @(posedge clk);
        @(negedge clk);
        s_start = 1'b0;
        while (!s_done) begin
            @(posedge clk);
            @(negedge clk);
        end
        p = s_prod;
    endtask

    task automatic big_full(input logic [63:0] a, input logic [63:0] b, input string req);
        logic [127:0] p, e;
        int lat;
        bit bok;
        big_run(a, b, p, lat, bok);
        e = {64'd0, a} * {64'd0, b};
        check(p == e, req, "product", p, e);
        check(lat == 9, "R3", "latency", 128'(lat), 128'd9);
        check(bok && !busy, "R5", "busy window", {127'd0, bok}, 128'd1);
        @(negedge clk);
        check(!done, "R4", "done width", {127'd0, done}, 128'd0);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R3 watchdog: actual no completion expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [127:0] held, e;
        logic [11:0]  sp;
        int cnt;
        rst = 1'b1; start = 1'b0; s_start = 1'b0;
        a_in = '0; b_in = '0; s_a = '0; s_b = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check(!busy && !done && !s_busy && !s_done, "R1", "flags after reset",
              {126'd0, busy, done}, 128'd0);
        check(prod == '0 && s_prod == '0, "R1", "product after reset", prod, 128'd0);

        // R8 all ones, plus boundary operands for R2
        big_full(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, "R8");
        check(prod == 128'hFFFF_FFFF_FFFF_FFFE_0000_0000_0000_0001, "R8", "literal",
              prod, 128'hFFFF_FFFF_FFFF_FFFE_0000_0000_0000_0001);
        big_full(64'd0, 64'hFFFF_FFFF_FFFF_FFFF, "R2");
        big_full(64'h0000_0001_0000_0000, 64'h0000_0001_0000_0000, "R2");
        big_full(64'h0000_0000_FFFF_FFFF, 64'hFFFF_FFFF_0000_0000, "R2");
        big_full(64'hFFFF_FFFF_0000_0001, 64'h8000_0000_FFFF_FFFF, "R2");
        for (int i = 0; i < 20; i++)
            big_full({$urandom, $urandom}, {$urandom, $urandom}, "R2");

        // R7 result holds while idle and inputs change
        held = prod;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            a_in = {$urandom, $urandom}; b_in = {$urandom, $urandom};
        end
        @(negedge clk);
        check(prod == held, "R7", "idle hold", prod, held);

        // R6 start during busy is ignored
        @(negedge clk);
        start = 1'b1; a_in = 64'h1234_5678_9ABC_DEF0; b_in = 64'h0FED_CBA9_8765_4321;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0; cnt = 0;
        repeat (3) begin @(posedge clk); @(negedge clk); cnt++; end
        start = 1'b1; a_in = 64'hFFFF_FFFF_FFFF_FFFF; b_in = 64'h3;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0; cnt++;
        while (!done && cnt < 40) begin @(posedge clk); @(negedge clk); cnt++; end
        e = {64'd0, 64'h1234_5678_9ABC_DEF0} * {64'd0, 64'h0FED_CBA9_8765_4321};
        check(prod == e, "R6", "product kept", prod, e);
        check(cnt == 9, "R6", "timing kept", 128'(cnt), 128'd9);
        @(negedge clk);
        check(!busy && !done, "R6", "no queued run", {126'd0, busy, done}, 128'd0);

        // R2 exhaustive sweep on the three-bit-word instance
        for (int a = 0; a < 64; a++) begin
            for (int b = 0; b < 64; b++) begin
                small_run(6'(a), 6'(b), sp);
                check(sp == 12'(a * b), "R2", "small sweep", 128'(sp), 128'(a * b));
            end
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule